// File: doc/BRIEF.md
# Multi-Channel Output Compare Timer

A 16-bit up-counter advances by one on every count-enable pulse while it is running and compares its value against four compare registers, A to D. Each compare channel owns one output pin. When a count pulse arrives while the counter equals a channel's compare value, that channel's pin is driven low, driven high, inverted or left alone, according to its programmed action. A match also raises a sticky interrupt flag, and so does a counter wrap from FFFFh.

The counter runs either free, with a period of 65536 counts, or clears on compare A, with a period of compare A plus one. Writing 1 to the run bit starts counting and loads every pin with its programmed initial level. Counting stops in one of two ways. In software-stop mode, writing 0 to the run bit halts the count and freezes every pin. In one-shot mode, the compare A match halts the count by itself, and the pins keep the levels that match produced. A remap option hands control of pin A to compare C and pin B to compare D. Software reaches all state through a small word-wide register port.

Top module: `cmp_timer`

## Requirements
- R1: While running, each cycle with `cnt_en_i` high advances the count by exactly one. The count holds when `cnt_en_i` is low or the timer is stopped.
- R2: With the clear bit (CTRL bit 2) at 0, the count wraps from FFFFh to 0000h. The count pulse taken at FFFFh sets the overflow flag, which is FLAG bit 4.
- R3: With the clear bit at 1, the count pulse taken while the count equals compare A loads 0000h, so the period is compare A plus one.
- R4: A count pulse taken while the count equals compare x applies that channel's action at the same clock edge as the count step. The action is CFG bits [4x+1:4x]: 00 hold, 01 low, 10 high, 11 invert.
- R5: A CTRL write with bit 0 set, made while the timer is stopped, starts the count and loads every pin level from its initial-level bit, CFG bit 4x+2.
- R6: With CTRL bit 1 at 1, a CTRL write with bit 0 at 0 stops the count. Count and pins then hold their values.
- R7: With CTRL bit 1 at 0, the count stops by itself at the compare A match, and the pins keep the levels of that match. A CTRL write with bits 1:0 at 00 does not stop a running count.
- R8: FLAG bits 3:0 record matches on A to D. A flag stays set until a FLAG write with a 1 in that bit clears it. A new event in the same cycle wins over the clear.
- R9: `irq_o` is high exactly when any FLAG bit is set.
- R10: With CTRL bit 3 set, matches on C and D act on pins A and B, using the C and D actions. The C and D actions win over A and B when both match in the same cycle. Pins C and D then output 0.
- R11: A pin whose enable bit, CFG bit 4x+3, is 0 outputs 0.
- R12: A write to the count register loads the written value at that edge, overriding any count step.
- R13: Register addresses are: 0 CTRL (bit 0 reads the run state), 1 CFG, 2 COUNT, 3 FLAG, 4 to 7 compare A to D. All read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Count-enable pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` (combinational) |
| pin_o | output | 4 | Compare output pins A to D (bit 0 is pin A) |
| irq_o | output | 1 | High while any interrupt flag is set |

## Verification
A wrong count shows up on the count readback in the very next cycle. It shows on the pins only later, when a match falls on a different pulse than it should, which can be up to a full period away. A wrong run state or a wrong pin level is visible on `pin_o` or on the CTRL readback one edge after it arises. A flag that clears itself, or one that was never set, changes `irq_o` within a single cycle. The bench therefore compares the pins, the interrupt line and the addressed read data against its model on every clock.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_INV  = 2'b11
  } act_e;

  typedef struct packed {
    logic en;
    logic init;
    act_e act;
  } ch_cfg_t;

  localparam int CFG_W = 4;

  localparam int ADR_CTRL = 0;
  localparam int ADR_CFG  = 1;
  localparam int ADR_CNT  = 2;
  localparam int ADR_FLAG = 3;
  localparam int ADR_CMP0 = 4;

  localparam int CB_RUN    = 0;
  localparam int CB_SWSTOP = 1;
  localparam int CB_CLR    = 2;
  localparam int CB_REMAP  = 3;

  function automatic logic apply_act(act_e a, logic cur);
    case (a)
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_INV:  return ~cur;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter
  import cmp_timer_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cnt_en_i,
  input  logic                    clr_mode_i,
  input  logic                    stop_sel_i,
  input  logic                    start_wr_i,
  input  logic                    stop_wr_i,
  input  logic                    cnt_wr_i,
  input  logic [CW-1:0]           cnt_wdata_i,
  input  logic [NCH-1:0][CW-1:0]  cmp_i,
  output logic [CW-1:0]           cnt_o,
  output logic                    run_o,
  output logic [NCH-1:0]          ev_o,
  output logic                    ovf_o,
  output logic                    start_pulse_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          step;

  assign step = run_q & cnt_en_i;

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    assign ev_o[i] = step & (cnt_q == cmp_i[i]);
  end

  assign ovf_o         = step & (&cnt_q);
  assign start_pulse_o = start_wr_i & ~run_q;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_wr_i)                  cnt_d = cnt_wdata_i;
    else if (step) begin
      if (clr_mode_i && ev_o[0])   cnt_d = '0;
      else                         cnt_d = cnt_q + CW'(1);
    end
  end

  always_comb begin
    run_d = run_q;
    if (start_wr_i)                          run_d = 1'b1;
    else if (stop_wr_i)                      run_d = 1'b0;
    else if (ev_o[0] && !stop_sel_i)         run_d = 1'b0;  // one-shot stop
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/cmp_timer_pin.sv
module cmp_timer_pin
  import cmp_timer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_pulse_i,
  input  logic init_i,
  input  logic own_ev_i,
  input  act_e own_act_i,
  input  logic alt_sel_i,
  input  logic alt_ev_i,
  input  act_e alt_act_i,
  output logic level_o
);
  logic lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (start_pulse_i)              lvl_d = init_i;
    else if (alt_sel_i && alt_ev_i) lvl_d = apply_act(alt_act_i, lvl_q);
    else if (own_ev_i)              lvl_d = apply_act(own_act_i, lvl_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_d;
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 4,
  parameter int AW  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [CW-1:0]           wdata_i,
  input  logic                    run_i,
  input  logic [CW-1:0]           cnt_i,
  input  logic [NCH-1:0]          ev_i,
  input  logic                    ovf_i,
  output ch_cfg_t [NCH-1:0]       cfg_o,
  output logic [NCH-1:0][CW-1:0]  cmp_o,
  output logic                    stop_sel_o,
  output logic                    clr_mode_o,
  output logic                    remap_o,
  output logic                    ctrl_wr_o,
  output logic                    start_wr_o,
  output logic                    stop_wr_o,
  output logic                    cnt_wr_o,
  output logic                    cfg_wr_o,
  output logic                    flag_wr_o,
  output logic [NCH:0]            flags_o,
  output logic [CW-1:0]           rdata_o
);
  localparam int FW = NCH + 1;

  ch_cfg_t [NCH-1:0]      cfg_q;
  logic [NCH-1:0][CW-1:0] cmp_q;
  logic                   stop_sel_q, clr_mode_q, remap_q;
  logic [FW-1:0]          flags_q, clr_mask;

  assign ctrl_wr_o  = we_i & (addr_i == AW'(ADR_CTRL));
  assign cfg_wr_o   = we_i & (addr_i == AW'(ADR_CFG));
  assign cnt_wr_o   = we_i & (addr_i == AW'(ADR_CNT));
  assign flag_wr_o  = we_i & (addr_i == AW'(ADR_FLAG));
  assign start_wr_o = ctrl_wr_o & wdata_i[CB_RUN];
  assign stop_wr_o  = ctrl_wr_o & ~wdata_i[CB_RUN] & wdata_i[CB_SWSTOP];
  assign clr_mask   = flag_wr_o ? wdata_i[FW-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_sel_q <= 1'b0;
      clr_mode_q <= 1'b0;
      remap_q    <= 1'b0;
      flags_q    <= '0;
    end else begin
      if (ctrl_wr_o) begin
        stop_sel_q <= wdata_i[CB_SWSTOP];
        clr_mode_q <= wdata_i[CB_CLR];
        remap_q    <= wdata_i[CB_REMAP];
      end
      flags_q <= (flags_q & ~clr_mask) | {ovf_i, ev_i};  // set wins
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[i] <= '0;
        cmp_q[i] <= '0;
      end else begin
        if (cfg_wr_o) cfg_q[i] <= wdata_i[CFG_W*i +: CFG_W];
        if (we_i && addr_i == AW'(ADR_CMP0 + i)) cmp_q[i] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADR_CTRL)) begin
      rdata_o[CB_RUN]    = run_i;
      rdata_o[CB_SWSTOP] = stop_sel_q;
      rdata_o[CB_CLR]    = clr_mode_q;
      rdata_o[CB_REMAP]  = remap_q;
    end else if (addr_i == AW'(ADR_CFG)) begin
      for (int i = 0; i < NCH; i++) rdata_o[CFG_W*i +: CFG_W] = cfg_q[i];
    end else if (addr_i == AW'(ADR_CNT)) begin
      rdata_o = cnt_i;
    end else if (addr_i == AW'(ADR_FLAG)) begin
      rdata_o[FW-1:0] = flags_q;
    end else begin
      for (int i = 0; i < NCH; i++)
        if (addr_i == AW'(ADR_CMP0 + i)) rdata_o = cmp_q[i];
    end
  end

  assign cfg_o      = cfg_q;
  assign cmp_o      = cmp_q;
  assign stop_sel_o = stop_sel_q;
  assign clr_mode_o = clr_mode_q;
  assign remap_o    = remap_q;
  assign flags_o    = flags_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 4,
  parameter int AW  = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cnt_en_i,
  input  logic           reg_we_i,
  input  logic [AW-1:0]  reg_addr_i,
  input  logic [CW-1:0]  reg_wdata_i,
  output logic [CW-1:0]  reg_rdata_o,
  output logic [NCH-1:0] pin_o,
  output logic           irq_o
);
  localparam int HALF = NCH / 2;

  ch_cfg_t [NCH-1:0]      cfg;
  logic [NCH-1:0][CW-1:0] cmp;
  logic [CW-1:0]          cnt;
  logic [NCH-1:0]         ev, lvl;
  logic [NCH:0]           flags;
  logic run, ovf, start_pulse;
  logic stop_sel, clr_mode, remap;
  logic ctrl_wr, start_wr, stop_wr, cnt_wr, cfg_wr, flag_wr;

  cmp_timer_regs #(.CW(CW), .NCH(NCH), .AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .run_i(run), .cnt_i(cnt), .ev_i(ev), .ovf_i(ovf),
    .cfg_o(cfg), .cmp_o(cmp),
    .stop_sel_o(stop_sel), .clr_mode_o(clr_mode), .remap_o(remap),
    .ctrl_wr_o(ctrl_wr), .start_wr_o(start_wr), .stop_wr_o(stop_wr),
    .cnt_wr_o(cnt_wr), .cfg_wr_o(cfg_wr), .flag_wr_o(flag_wr),
    .flags_o(flags), .rdata_o(reg_rdata_o)
  );

  cmp_timer_counter #(.CW(CW), .NCH(NCH)) u_cnt (
    .clk_i, .rst_ni, .cnt_en_i,
    .clr_mode_i(clr_mode), .stop_sel_i(stop_sel),
    .start_wr_i(start_wr), .stop_wr_i(stop_wr),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(reg_wdata_i),
    .cmp_i(cmp), .cnt_o(cnt), .run_o(run),
    .ev_o(ev), .ovf_o(ovf), .start_pulse_o(start_pulse)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_pin
    if (i < HALF) begin : g_pair
      cmp_timer_pin u_pin (
        .clk_i, .rst_ni, .start_pulse_i(start_pulse),
        .init_i(cfg[i].init), .own_ev_i(ev[i]), .own_act_i(cfg[i].act),
        .alt_sel_i(remap), .alt_ev_i(ev[i+HALF]), .alt_act_i(cfg[i+HALF].act),
        .level_o(lvl[i])
      );
      assign pin_o[i] = cfg[i].en & lvl[i];
    end else begin : g_solo
      cmp_timer_pin u_pin (
        .clk_i, .rst_ni, .start_pulse_i(start_pulse),
        .init_i(cfg[i].init), .own_ev_i(ev[i]), .own_act_i(cfg[i].act),
        .alt_sel_i(1'b0), .alt_ev_i(1'b0), .alt_act_i(ACT_HOLD),
        .level_o(lvl[i])
      );
      assign pin_o[i] = cfg[i].en & lvl[i] & ~remap;  // taken over by remap
    end
  end

  assign irq_o = |flags;
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cnt_en_i,
  input logic           run,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  cmp_a,
  input logic           clr_mode,
  input logic           stop_sel,
  input logic           remap,
  input logic           ctrl_wr,
  input logic           cnt_wr,
  input logic           cfg_wr,
  input logic           flag_wr,
  input logic [NCH:0]   flags,
  input logic [NCH-1:0] pin_o
);
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && cnt_en_i && !cnt_wr && !(clr_mode && cnt == cmp_a) |=> (cnt - $past(cnt)) == CW'(1)); // R1
  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run && cnt_en_i) && !cnt_wr |=> $stable(cnt)); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && cnt_en_i && !cnt_wr && (&cnt) |=> cnt == '0); // R2
  AST_OVF_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && cnt_en_i && (&cnt) |=> flags[NCH]); // R2
  AST_CLR_ON_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && cnt_en_i && !cnt_wr && clr_mode && cnt == cmp_a |=> cnt == '0); // R3
  AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run && !ctrl_wr && !cfg_wr |=> $stable(pin_o)); // R6
  AST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && cnt_en_i && !stop_sel && cnt == cmp_a && !ctrl_wr |=> !run); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_wr |=> (flags & $past(flags)) == $past(flags)); // R8
  AST_REMAP_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap |-> pin_o[NCH-1:NCH/2] == '0); // R10
endmodule

bind cmp_timer cmp_timer_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i),
  .run(run), .cnt(cnt), .cmp_a(cmp[0]),
  .clr_mode(clr_mode), .stop_sel(stop_sel), .remap(remap),
  .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr), .cfg_wr(cfg_wr), .flag_wr(flag_wr),
  .flags(flags), .pin_o(pin_o)
);

// File: tb/cmp_timer_test.sv
module cmp_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd2;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  pin;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit rnd_mode = 0;
  bit en_all = 1;
  logic [15:0] lfsr = 16'hACE1;

  cmp_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .pin_o(pin), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int m_cnt;
  int m_cmp[4];
  bit m_run, m_ss, m_clr, m_rmp;
  bit [15:0] m_cfg;
  bit [4:0]  m_flg;
  bit [3:0]  m_lvl;
  bit [3:0]  m_ev;
  bit        m_step, m_ovf, m_run_old;

  function automatic bit act_fn(bit [1:0] a, bit cur);
    case (a)
      2'b01: return 1'b0;
      2'b10: return 1'b1;
      2'b11: return ~cur;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_ss = 0; m_clr = 0; m_rmp = 0;
      m_cfg = 0; m_flg = 0; m_lvl = 0;
      for (int k = 0; k < 4; k++) m_cmp[k] = 0;
    end else begin
      m_run_old = m_run;
      m_step = m_run && cnt_en;
      for (int k = 0; k < 4; k++) m_ev[k] = m_step && (m_cnt == m_cmp[k]);
      m_ovf = m_step && (m_cnt == 65535);
      for (int k = 0; k < 4; k++) begin
        if (k < 2 && m_rmp && m_ev[k+2]) m_lvl[k] = act_fn(m_cfg[4*(k+2) +: 2], m_lvl[k]);
        else if (m_ev[k])                m_lvl[k] = act_fn(m_cfg[4*k +: 2], m_lvl[k]);
      end
      if (m_step) m_cnt = (m_clr && m_ev[0]) ? 0 : (m_cnt + 1) % 65536;
      if (m_step && m_ev[0] && !m_ss) m_run = 0;
      if (we && addr == 3'd3) m_flg = m_flg & ~wdata[4:0];
      m_flg = m_flg | {m_ovf, m_ev};
      if (we) begin
        case (addr)
          3'd0: begin
            if (wdata[0]) begin
              if (!m_run_old) for (int k = 0; k < 4; k++) m_lvl[k] = m_cfg[4*k+2];
              m_run = 1;
            end else if (wdata[1]) m_run = 0;
            m_ss = wdata[1]; m_clr = wdata[2]; m_rmp = wdata[3];
          end
          3'd1: m_cfg = wdata;
          3'd2: m_cnt = int'(wdata);
          3'd3: ;
          default: m_cmp[int'(addr) - 4] = int'(wdata);
        endcase
      end
    end
  end

  function automatic int exp_pin();
    int p = 0;
    for (int k = 0; k < 4; k++)
      if (m_cfg[4*k+3] && m_lvl[k] && !(m_rmp && k >= 2)) p |= (1 << k);
    return p;
  endfunction

  function automatic int exp_rd(logic [2:0] a);
    case (a)
      3'd0: return int'({m_rmp, m_clr, m_ss, m_run});
      3'd1: return int'(m_cfg);
      3'd2: return m_cnt;
      3'd3: return int'(m_flg);
      default: return m_cmp[int'(a) - 4];
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4/R10/R11 pins vs model", int'(pin), exp_pin());
      chk("R9 irq vs model", int'(irq), int'(|m_flg));
      chk("R13 rdata vs model", int'(rdata), exp_rd(addr));
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cnt_en = rnd_mode ? lfsr[0] : en_all;
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    we = 1'b1; addr = a[2:0]; wdata = d[15:0];
    @(posedge clk); #1;
    we = 1'b0; addr = 3'd2; wdata = '0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    @(posedge clk); #1 addr = a[2:0];
    @(negedge clk);
    chk(req, int'(rdata), exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    for (int a = 0; a < 8; a++) rd_chk(a, 0, "R13 reset read");
    @(negedge clk);
    chk("R11 reset pins", int'(pin), 0);
    chk("R9 reset irq", int'(irq), 0);

    // A toggle/init1, B high/init0, C low/init1, D toggle/init0, all enabled
    wr(1, 'hBDAF);
    wr(4, 9); wr(5, 3); wr(6, 5); wr(7, 7);
    rd_chk(1, 'hBDAF, "R13 cfg readback");
    rd_chk(6, 5, "R13 compare C readback");

    // software stop, free running
    en_all = 1;
    wr(0, 3);
    @(negedge clk);
    chk("R5 initial levels at start", int'(pin), 'b0101);
    repeat (4) @(posedge clk);
    wr(0, 2);
    rd_chk(2, 6, "R1 count after six pulses");
    @(negedge clk);
    chk("R4 pins after B high and C low", int'(pin), 'b0011);
    repeat (10) @(posedge clk);
    rd_chk(2, 6, "R6 count holds after stop");
    chk("R6 pins hold after stop", int'(pin), 'b0011);
    rd_chk(0, 'h2, "R6 run bit clear");

    // clear on compare A: period 10
    wr(2, 0);
    wr(0, 7);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R3 count back to zero after A+1 pulses", int'(rdata), 0);
    wr(0, 6);

    // one-shot stop on compare A
    wr(3, 'h1F);
    wr(2, 0);
    wr(0, 5);
    wr(0, 4);
    rd_chk(0, 5, "R7 zero write leaves count running");
    repeat (30) @(posedge clk);
    rd_chk(0, 4, "R7 stopped at A match");
    rd_chk(2, 0, "R7 R3 count cleared at stop");
    chk("R7 pins keep match levels", int'(pin), 'b1010);
    rd_chk(3, 'h0F, "R8 match flags A-D");
    chk("R9 irq with flags set", int'(irq), 1);

    // write-1-to-clear
    wr(3, 3);
    rd_chk(3, 'hC, "R8 partial clear");
    wr(3, 'h1F);
    rd_chk(3, 0, "R8 full clear");
    chk("R9 irq after clear", int'(irq), 0);

    // wrap in free mode
    wr(2, 'hFFFC);
    rd_chk(2, 'hFFFC, "R12 count write while stopped");
    wr(0, 3);
    repeat (8) @(posedge clk);
    wr(0, 2);
    rd_chk(2, 6, "R2 count after wrap");
    rd_chk(3, 'h16, "R2 overflow flag with B and C");

    // count write while running
    wr(0, 3);
    wr(2, 100);
    @(negedge clk);
    chk("R12 write overrides step", int'(rdata), 100);
    wr(0, 2);

    // remap
    wr(2, 0);
    wr(0, 'hF);
    @(negedge clk);
    chk("R10 R5 remap start levels", int'(pin), 'b0001);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R10 C drives pin A low", int'(pin), 'b0010);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 D toggles pin B", int'(pin), 'b0000);
    wr(0, 'hE);

    // enables off
    wr(1, 'h3527);
    @(negedge clk);
    chk("R11 disabled pins low", int'(pin), 0);
    rd_chk(1, 'h3527, "R13 cfg readback");

    // irregular pulses across modes
    wr(1, 'hBDAF);
    rnd_mode = 1;
    wr(0, 7);
    repeat (300) @(posedge clk);
    wr(4, 20);
    repeat (200) @(posedge clk);
    wr(0, 'hF);
    repeat (200) @(posedge clk);
    wr(0, 'hE);
    wr(0, 5);
    repeat (200) @(posedge clk);
    wr(0, 3);
    wr(2, 'hFFF0);
    repeat (100) @(posedge clk);
    wr(0, 2);
    rnd_mode = 0;
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule